// File: doc/BRIEF.md
# Alternate-Phase Dual-Channel DAC Front-End

This block is the digital side of a two-channel converter whose two channels share one 10-bit parallel sample bus. A word meant for channel 1 is taken from the bus on a rising clock edge. A word meant for channel 2 is taken on a falling edge. The source therefore interleaves the two sample streams on the one bus, half a clock apart. Each channel holds a capture stage and a code register. A captured word reaches the channel's code output one edge of the same polarity later, so the two codes change on opposite clock phases. The analog current array, the reference and the load resistors are outside this block. Only the digital codes and the status flags leave it.

The bus has no valid/ready handshake and no back-pressure. While the active-low select is low and the converter is running, each edge of the relevant polarity takes a word. The source must present a word before every such edge, with at least 10 ns of setup and 0 ns of hold, at clock rates up to 40 MHz. Raising the select stops all captures, and both channels then keep their current codes.

A power-mode controller passes the power-down and enable pins through a two-flop synchroniser and decodes them. The decode gives shutdown, standby, or a request to run. A request to run first passes through a timed wake-up phase. The default length is 2000 cycles, about 50 µs at 40 MHz. Outside the running state the output enables are low and both codes read as zero, which is the grounded output state. The code registers are frozen during this time, so the pre-sleep codes come back when running resumes.

Top module: `altphase_dac_fe`

## Requirements
- R1: While `rst_n` is low, `ch1_code` and `ch2_code` are 0, `ch1_oe`, `ch2_oe` and `ready` are 0, and `mode` is 0 (shutdown).
- R2: With `cs_n` low and `ready` high, the word on `din` (bit 0 LSB, bit 9 MSB) at a rising edge appears on `ch1_code` after the next rising edge.
- R3: With `cs_n` low and `ready` high, the word on `din` at a falling edge appears on `ch2_code` after the next falling edge.
- R4: While `cs_n` is high, no word is captured. Both codes keep their values whatever `din` does.
- R5: The `mode` encoding is: 0 = shutdown, selected whenever `pwr_dn` is 1, whatever `dac_en` is; 1 = standby, selected when `pwr_dn` is 0 and `dac_en` is 0; 2 = waking; 3 = running. A run request (`pwr_dn` 0, `dac_en` 1) from mode 0 or 1 enters mode 2.
- R6: Mode pins pass through two synchroniser flops. A change on the pins before rising edge k shows on `mode` after edge k+2, and not before.
- R7: `ready` (mode 3) rises exactly WAKE_CYCLES rising edges after mode 2 is entered. A run request that is withdrawn during waking returns the block to mode 0 or 1 without raising `ready`.
- R8: In modes 0, 1 and 2, both codes read 0, the output enables are low, and bus words offered with `cs_n` low are not captured.
- R9: When mode 3 is reached again, both channels show the codes they held before leaving mode 3.
- R10: `ch1_oe` and `ch2_oe` are high exactly when `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge serves channel 1, falling edge channel 2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high blocks all captures |
| din | input | 10 | Shared sample bus, bit 0 LSB |
| pwr_dn | input | 1 | Power-down pin, 1 forces shutdown |
| dac_en | input | 1 | Enable pin, 1 requests running when not powered down |
| ch1_code | output | 10 | Channel 1 code, 0 when not running |
| ch2_code | output | 10 | Channel 2 code, 0 when not running |
| ch1_oe | output | 1 | Channel 1 output enable |
| ch2_oe | output | 1 | Channel 2 output enable |
| mode | output | 2 | Power mode: 0 shutdown, 1 standby, 2 waking, 3 running |
| ready | output | 1 | Wake-up count finished, block running |

## Verification
The main path is driven with pairs of complementary and alternating-bit words, all zeros against all ones, and single set bits at either end of the word. A channel swap, a lost edge polarity or a stuck or reversed bit each gives a different miscompare. Each pair puts different words on the rising and falling halves of one cycle. This shows that each channel takes only its own phase and that its output lags by exactly one edge of that phase. The power sequences check that the mode changes on the third edge after the pins change. They run shutdown with the enable pin both low and high, and they abort a wake-up partway through. Bus traffic offered during standby must leave no trace once running resumes. This separates a true freeze of the code registers from simple output blanking.

// File: rtl/altphase_dac_fe_pkg.sv
package altphase_dac_fe_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_IDLE = 2'd1,
    PM_WAKE = 2'd2,
    PM_RUN  = 2'd3
  } pmode_e;
endpackage

// File: rtl/altphase_pm_ctrl.sv
module altphase_pm_ctrl
  import altphase_dac_fe_pkg::*;
#(
  parameter int WAKE_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_dn_i,
  input  logic   dac_en_i,
  output pmode_e mode_o,
  output logic   run_o
);
  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(WAKE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] pd_sh, en_sh;
  logic                   pd_s, en_s, want_run;
  pmode_e                 state_q, state_d, rest_mode;
  logic [CW-1:0]          cnt_q;

  // two-flop synchronisers; power-down resets asserted so the block wakes in shutdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sh <= '1;
      en_sh <= '0;
    end else begin
      pd_sh <= {pd_sh[SYNC_STAGES-2:0], pwr_dn_i};
      en_sh <= {en_sh[SYNC_STAGES-2:0], dac_en_i};
    end
  end

  assign pd_s      = pd_sh[SYNC_STAGES-1];
  assign en_s      = en_sh[SYNC_STAGES-1];
  assign want_run  = !pd_s && en_s;
  assign rest_mode = pd_s ? PM_OFF : PM_IDLE;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_OFF, PM_IDLE: state_d = want_run ? PM_WAKE : rest_mode;
      PM_WAKE: begin
        if (!want_run)             state_d = rest_mode;
        else if (cnt_q == CNT_LAST) state_d = PM_RUN;
      end
      PM_RUN:  if (!want_run) state_d = rest_mode;
      default: state_d = PM_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == PM_WAKE) ? cnt_q + 1'b1 : '0;
    end
  end

  assign mode_o = state_q;
  assign run_o  = (state_q == PM_RUN);
endmodule

// File: rtl/altphase_chan_pipe.sv
module altphase_chan_pipe #(
  parameter int DATA_W = 10,
  parameter bit RISING = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] code_o
);
  logic [DATA_W-1:0] cap_q, out_q;

  generate
    if (RISING) begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q <= '0;
          out_q <= '0;
        end else begin
          if (load_i) cap_q <= din_i;
          out_q <= cap_q;
        end
      end
    end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q <= '0;
          out_q <= '0;
        end else begin
          if (load_i) cap_q <= din_i;
          out_q <= cap_q;
        end
      end
    end
  endgenerate

  assign code_o = out_q;
endmodule

// File: rtl/altphase_dac_fe.sv
module altphase_dac_fe
  import altphase_dac_fe_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int WAKE_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] din,
  input  logic              pwr_dn,
  input  logic              dac_en,
  output logic [DATA_W-1:0] ch1_code,
  output logic [DATA_W-1:0] ch2_code,
  output logic              ch1_oe,
  output logic              ch2_oe,
  output logic [1:0]        mode,
  output logic              ready
);
  localparam int NUM_CH = 2;

  pmode_e            pm_mode;
  logic              run;
  logic [DATA_W-1:0] code_q [NUM_CH];

  altphase_pm_ctrl #(
    .WAKE_CYCLES(WAKE_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_dn_i(pwr_dn),
    .dac_en_i(dac_en),
    .mode_o  (pm_mode),
    .run_o   (run)
  );

  // channel 0 works on the rising edge, channel 1 on the falling edge
  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      altphase_chan_pipe #(
        .DATA_W(DATA_W),
        .RISING(g == 0)
      ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(run && !cs_n),
        .din_i (din),
        .code_o(code_q[g])
      );
    end
  endgenerate

  assign ch1_code = run ? code_q[0] : '0;
  assign ch2_code = run ? code_q[1] : '0;
  assign ch1_oe   = run;
  assign ch2_oe   = run;
  assign mode     = pm_mode;
  assign ready    = run;
endmodule

// File: rtl/altphase_dac_fe_chk.sv
module altphase_dac_fe_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              pwr_dn,
  input logic              dac_en,
  input logic [DATA_W-1:0] ch1_code,
  input logic [DATA_W-1:0] ch2_code,
  input logic              ch1_oe,
  input logic              ch2_oe,
  input logic [1:0]        mode,
  input logic              ready
);
  logic [2:0] age;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign settled = (age >= 3'd4);

  assert_blank_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (ch1_code == '0) && (ch2_code == '0) && !ch1_oe && !ch2_oe);

  assert_ready_from_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(mode) == 2'd2);

  assert_standby_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && mode == 2'd1 && $past(mode) != 2'd1)
      |-> (!$past(pwr_dn, 3) && !$past(dac_en, 3)));

  assert_shutdown_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && mode == 2'd0 && $past(mode) != 2'd0) |-> $past(pwr_dn, 3));

  assert_hold_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && ready && $past(ready) && $past(cs_n, 2)) |-> $stable(ch1_code));
endmodule

bind altphase_dac_fe altphase_dac_fe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .pwr_dn  (pwr_dn),
  .dac_en  (dac_en),
  .ch1_code(ch1_code),
  .ch2_code(ch2_code),
  .ch1_oe  (ch1_oe),
  .ch2_oe  (ch2_oe),
  .mode    (mode),
  .ready   (ready)
);

// File: tb/altphase_dac_fe_bench.sv
module altphase_dac_fe_bench;
  localparam int CLK_PERIOD = 20;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int DW         = 10;
  localparam int WK         = 8;
  localparam int NV         = 8;
  // {channel 1 word, channel 2 word}
  localparam logic [19:0] VEC [NV] = '{
    {10'h000, 10'h3FF}, {10'h155, 10'h2AA}, {10'h001, 10'h200}, {10'h3FF, 10'h000},
    {10'h2AA, 10'h155}, {10'h200, 10'h001}, {10'h123, 10'h0F0}, {10'h30C, 10'h0C3}
  };

  logic          clk = 1'b0;
  logic          rst_n, cs_n, pwr_dn, dac_en;
  logic [DW-1:0] din;
  logic [DW-1:0] ch1_code, ch2_code;
  logic          ch1_oe, ch2_oe, ready;
  logic [1:0]    mode;
  int nchk = 0;
  int nerr = 0;

  altphase_dac_fe #(.DATA_W(DW), .WAKE_CYCLES(WK)) u_altphase_dac_fe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .pwr_dn(pwr_dn), .dac_en(dac_en),
    .ch1_code(ch1_code), .ch2_code(ch2_code), .ch1_oe(ch1_oe), .ch2_oe(ch2_oe),
    .mode(mode), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_pins(input logic pd, input logic en);
    @(negedge clk); #(Q);
    pwr_dn = pd;
    dac_en = en;
  endtask

  task automatic edges_to_mode(input logic [1:0] m, input int exp_n, input string tag);
    int n = 0;
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk); #(Q);
      if (mode == m) begin n = k; break; end
    end
    chk(tag, n, exp_n);
  endtask

  task automatic check_blank(input string tag);
    chk({tag, " ch1_code"}, int'(ch1_code), 0);
    chk({tag, " ch2_code"}, int'(ch2_code), 0);
    chk({tag, " oe"}, int'({ch1_oe, ch2_oe}), 0);
  endtask

  task automatic wake_up(input string tag);
    set_pins(1'b0, 1'b1);
    edges_to_mode(2'd2, 3, {tag, " R6 waking after sync"});
    check_blank({tag, " R8 waking"});
    edges_to_mode(2'd3, WK, {tag, " R7 wake length"});
    chk({tag, " R10 oe"}, int'({ch1_oe, ch2_oe, ready}), 7);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nerr++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; din = '0; pwr_dn = 1'b1; dac_en = 1'b0;
    #(CLK_PERIOD * 3 + Q);
    check_blank("R1 reset");
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset ready", int'(ready), 0);
    rst_n = 1'b1;
    cs_n  = 1'b0;
    wake_up("bring-up");

    // table walk: ch1 word before the rising edge, ch2 word before the falling edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); #(Q);
      if (i >= 2) chk("R3 ch2 falling-edge path", int'(ch2_code), int'(VEC[i-2][9:0]));
      din = VEC[i][19:10];
      @(posedge clk); #(Q);
      if (i >= 1) chk("R2 ch1 rising-edge path", int'(ch1_code), int'(VEC[i-1][19:10]));
      din = VEC[i][9:0];
    end
    @(negedge clk); #(Q);
    chk("R3 ch2 falling-edge path", int'(ch2_code), int'(VEC[NV-2][9:0]));
    cs_n = 1'b1;
    din  = 10'h3CC;
    repeat (2) @(posedge clk);
    #(Q) din = 10'h033;
    repeat (2) @(posedge clk);
    #(Q);
    chk("R4 deselected ch1 hold", int'(ch1_code), int'(VEC[NV-1][19:10]));
    chk("R4 deselected ch2 hold", int'(ch2_code), int'(VEC[NV-1][9:0]));

    // standby, with bus traffic offered while asleep
    set_pins(1'b0, 1'b0);
    edges_to_mode(2'd1, 3, "R5 standby decode");
    check_blank("R8 standby");
    cs_n = 1'b0;
    din  = 10'h0AB;
    repeat (4) @(posedge clk);
    #(Q);
    check_blank("R8 standby traffic");
    @(negedge clk); #(Q) cs_n = 1'b1;
    wake_up("from standby");
    chk("R9 ch1 restored", int'(ch1_code), int'(VEC[NV-1][19:10]));
    chk("R9 ch2 restored", int'(ch2_code), int'(VEC[NV-1][9:0]));

    // shutdown overrides an asserted enable
    set_pins(1'b1, 1'b1);
    edges_to_mode(2'd0, 3, "R5 shutdown with enable high");
    check_blank("R8 shutdown");
    wake_up("from shutdown");
    chk("R9 ch1 restored after shutdown", int'(ch1_code), int'(VEC[NV-1][19:10]));
    chk("R9 ch2 restored after shutdown", int'(ch2_code), int'(VEC[NV-1][9:0]));

    // aborted wake-up
    set_pins(1'b0, 1'b0);
    edges_to_mode(2'd1, 3, "R5 standby again");
    set_pins(1'b0, 1'b1);
    edges_to_mode(2'd2, 3, "R6 waking again");
    set_pins(1'b0, 1'b0);
    edges_to_mode(2'd1, 3, "R7 aborted wake to standby");
    chk("R7 aborted wake ready", int'(ready), 0);

    // fresh data after a full wake, channels given distinct end-of-range words
    wake_up("final");
    cs_n = 1'b0;
    @(negedge clk); #(Q) din = 10'h201;
    @(posedge clk); #(Q) din = 10'h102;
    @(negedge clk);
    @(posedge clk); #(Q);
    chk("R2 ch1 after rewake", int'(ch1_code), 10'h201);
    @(negedge clk); #(Q);
    chk("R3 ch2 after rewake", int'(ch2_code), 10'h102);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule